// File: doc/BRIEF.md
# Fixed-Function Event Counter Bank

This block holds a small bank of event counters, each tied to one dedicated event input. All counters are configured through one shared control word that is split into 4-bit fields, one field per counter. A field chooses whether its counter advances while the core runs in privileged (kernel) mode, in user mode, or both, and whether an overflow raises an interrupt. Writing a zero field stops a counter. Its value stays in place and can still be read.

Each counter also needs its own bit of a 64-bit global enable word, at position `FIXED_BASE + i`. When a counter wraps, it sets the matching bit of a 64-bit global overflow status word, at the same position. The surrounding logic merges that word with the status bits of other counter banks. A 64-bit overflow-clear strobe clears status bits in write-one-to-clear fashion. Software reaches the control word and the counter values through a simple register port. Writes replace a whole register, and reads return the current value with reserved bits reading zero. Software can therefore read a register, change some bits and write it back without corrupting anything.

Top module: `fxc_unit`

## Requirements
- R1: The field of counter i is control bits [4i+3:4i]. Field bit 0 lets the counter count while `user_mode_i` is 0 (kernel). Field bit 1 lets it count while `user_mode_i` is 1 (user).
- R2: Field bit 2 is reserved: it ignores writes and reads as 0. Control bits at and above position 4·NUM_FIXED also read as 0. The control word is at register address 0.
- R3: Counter i advances by exactly one on each clock edge where all three of the following hold: `event_i[i]` is 1, `glb_ctrl_i[FIXED_BASE+i]` is 1, and its field allows the current mode. Otherwise it holds its value.
- R4: A field of all zeros stops counter i. Its value stays readable at register address i+1.
- R5: Counters are CNT_W bits wide and wrap from all ones to zero. A write keeps only the low CNT_W bits. A read returns the value zero-extended to DATA_W.
- R6: A wrap of counter i sets `glb_status_o[FIXED_BASE+i]` on the same edge. All other status bits are always 0.
- R7: When `ovf_clr_valid_i` is 1, every status bit whose `ovf_clr_data_i` bit is 1 is cleared. If a new wrap of the same counter falls in the same cycle, the bit stays set.
- R8: `irq_o` is high for exactly the one cycle after a wrap, and only if bit 3 of that counter's field was 1 when the wrap happened.
- R9: A register write to a counter takes priority over an event in the same cycle. The written value is stored, and neither an increment nor a wrap occurs.
- R10: After reset, every counter, the control word, every status bit and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_i | input | NUM_FIXED | One event pulse per counter |
| user_mode_i | input | 1 | 1 = user mode, 0 = kernel mode |
| glb_ctrl_i | input | GLB_W | Global enable word; bits FIXED_BASE+i used |
| ovf_clr_valid_i | input | 1 | Overflow-clear strobe |
| ovf_clr_data_i | input | GLB_W | Bits to clear in the status word |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: 0 control, i+1 counter i |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read address, same map as writes |
| rd_data_o | output | DATA_W | Combinational read data |
| glb_status_o | output | GLB_W | Overflow status; bits FIXED_BASE+i driven |
| irq_o | output | 1 | Overflow interrupt pulse |

## Verification
Two events can land on the same status bit in one cycle: a counter wrap sets the bit, and the overflow-clear strobe removes it. The bench provokes this by loading a counter with all ones and then, in one cycle, asserting that counter's event together with a clear of its status bit. The bit must still be set and the interrupt must still fire. A counter write meeting an event in the same cycle is provoked the same way and judged by the read-back value. The random phase produces both collisions repeatedly, and its results are compared against a reference model in the bench.

// File: rtl/fxc_pkg.sv
`timescale 1ns/1ps
package fxc_pkg;
  localparam int FIELD_W = 4;

  typedef struct packed {
    logic pmi;   // interrupt on wrap
    logic rsvd;  // reserved, always zero
    logic usr;   // count in user mode
    logic krn;   // count in kernel mode
  } fxc_field_t;

  function automatic logic field_allows(fxc_field_t f, logic user_mode);
    return user_mode ? f.usr : f.krn;
  endfunction
endpackage

// File: rtl/fxc_rst_sync.sv
`timescale 1ns/1ps
module fxc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/fxc_ctrl_reg.sv
`timescale 1ns/1ps
module fxc_ctrl_reg #(
  parameter int NUM_FIXED = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en_i,
  input  logic [fxc_pkg::FIELD_W*NUM_FIXED-1:0] wr_data_i,
  output logic [fxc_pkg::FIELD_W*NUM_FIXED-1:0] ctrl_o
);
  localparam int CTRL_W = fxc_pkg::FIELD_W * NUM_FIXED;

  logic [CTRL_W-1:0] keep_mask;
  logic [CTRL_W-1:0] ctrl_d, ctrl_q;

  for (genvar i = 0; i < NUM_FIXED; i++) begin : g_mask
    assign keep_mask[fxc_pkg::FIELD_W*i +: fxc_pkg::FIELD_W] = 4'b1011;
  end

  always_comb begin
    ctrl_d = wr_data_i & keep_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/fxc_counter.sv
`timescale 1ns/1ps
module fxc_counter #(
  parameter int CNT_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  fxc_pkg::fxc_field_t field_i,
  input  logic               user_mode_i,
  input  logic               glb_en_i,
  input  logic               event_i,
  input  logic               load_en_i,
  input  logic [CNT_W-1:0]   load_val_i,
  output logic [CNT_W-1:0]   value_o,
  output logic               wrap_o
);
  logic             count_en;
  logic             upd_en;
  logic [CNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    count_en = event_i & glb_en_i & fxc_pkg::field_allows(field_i, user_mode_i);
    upd_en   = load_en_i | count_en;
    if (load_en_i) cnt_d = load_val_i;
    else           cnt_d = cnt_q + CNT_W'(1);
    wrap_o   = count_en & ~load_en_i & (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (upd_en) cnt_q <= cnt_d;
  end

  assign value_o = cnt_q;
endmodule

// File: rtl/fxc_status.sv
`timescale 1ns/1ps
module fxc_status #(
  parameter int NUM_FIXED = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FIXED-1:0] set_i,
  input  logic [NUM_FIXED-1:0] clr_i,
  input  logic [NUM_FIXED-1:0] pmi_i,
  output logic [NUM_FIXED-1:0] status_o,
  output logic                 irq_o
);
  logic [NUM_FIXED-1:0] stat_d, stat_q;
  logic                 irq_d, irq_q;

  always_comb begin
    stat_d = (stat_q & ~clr_i) | set_i;
    irq_d  = |(set_i & pmi_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/fxc_unit.sv
`timescale 1ns/1ps
module fxc_unit #(
  parameter int NUM_FIXED  = 3,
  parameter int CNT_W      = 48,
  parameter int DATA_W     = 64,
  parameter int GLB_W      = 64,
  parameter int FIXED_BASE = 32,
  parameter int ADDR_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FIXED-1:0] event_i,
  input  logic                 user_mode_i,
  input  logic [GLB_W-1:0]     glb_ctrl_i,
  input  logic                 ovf_clr_valid_i,
  input  logic [GLB_W-1:0]     ovf_clr_data_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [GLB_W-1:0]     glb_status_o,
  output logic                 irq_o
);
  localparam int CTRL_W = fxc_pkg::FIELD_W * NUM_FIXED;

  logic                 rst_n_s;
  logic [CTRL_W-1:0]    ctrl;
  logic                 ctrl_wr;
  logic [NUM_FIXED-1:0] wrap, pmi, clr, status;
  logic [CNT_W-1:0]     cnt_val [NUM_FIXED];

  fxc_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign ctrl_wr = wr_en_i && (wr_addr_i == '0);

  fxc_ctrl_reg #(.NUM_FIXED(NUM_FIXED)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en_i   (ctrl_wr),
    .wr_data_i (wr_data_i[CTRL_W-1:0]),
    .ctrl_o    (ctrl)
  );

  for (genvar i = 0; i < NUM_FIXED; i++) begin : g_cnt
    fxc_pkg::fxc_field_t fld;
    logic                ld;
    assign fld    = fxc_pkg::fxc_field_t'(ctrl[fxc_pkg::FIELD_W*i +: fxc_pkg::FIELD_W]);
    assign ld     = wr_en_i && (wr_addr_i == ADDR_W'(i + 1));
    assign pmi[i] = fld.pmi;
    assign clr[i] = ovf_clr_valid_i & ovf_clr_data_i[FIXED_BASE + i];

    fxc_counter #(.CNT_W(CNT_W)) u_counter (
      .clk         (clk),
      .rst_n       (rst_n_s),
      .field_i     (fld),
      .user_mode_i (user_mode_i),
      .glb_en_i    (glb_ctrl_i[FIXED_BASE + i]),
      .event_i     (event_i[i]),
      .load_en_i   (ld),
      .load_val_i  (wr_data_i[CNT_W-1:0]),
      .value_o     (cnt_val[i]),
      .wrap_o      (wrap[i])
    );
  end

  fxc_status #(.NUM_FIXED(NUM_FIXED)) u_status (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .set_i    (wrap),
    .clr_i    (clr),
    .pmi_i    (pmi),
    .status_o (status),
    .irq_o    (irq_o)
  );

  always_comb begin
    glb_status_o = '0;
    glb_status_o[FIXED_BASE +: NUM_FIXED] = status;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == '0) rd_data_o[CTRL_W-1:0] = ctrl;
    for (int i = 0; i < NUM_FIXED; i++) begin
      if (rd_addr_i == ADDR_W'(i + 1)) rd_data_o[CNT_W-1:0] = cnt_val[i];
    end
  end
endmodule

// File: rtl/fxc_unit_chk.sv
`timescale 1ns/1ps
module fxc_unit_chk #(
  parameter int NUM_FIXED  = 3,
  parameter int CNT_W      = 48,
  parameter int DATA_W     = 64,
  parameter int GLB_W      = 64,
  parameter int FIXED_BASE = 32,
  parameter int ADDR_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GLB_W-1:0]  glb_ctrl_i,
  input logic              ovf_clr_valid_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [GLB_W-1:0]  glb_status_o,
  input logic              irq_o
);
  localparam int CTRL_W = 4 * NUM_FIXED;
  localparam logic [GLB_W-1:0] OWN_BITS = ((GLB_W'(1) << NUM_FIXED) - GLB_W'(1)) << FIXED_BASE;

  // R6
  stray_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_status_o & ~OWN_BITS) == '0);

  // R7
  status_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(glb_status_o) & ~glb_status_o)) |-> $past(ovf_clr_valid_i));

  // R8
  irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|glb_status_o));

  // R2
  ctrl_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == '0) |-> ((rd_data_o >> CTRL_W) == '0));

  // R5
  cnt_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i != '0 && rd_addr_i <= ADDR_W'(NUM_FIXED)) |-> ((rd_data_o >> CNT_W) == '0));

  for (genvar i = 0; i < NUM_FIXED; i++) begin : g_fld
    // R2
    rsvd_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_i == '0) |-> !rd_data_o[4*i+2]);
    // R3
    gated_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(glb_status_o[FIXED_BASE+i]) |-> $past(glb_ctrl_i[FIXED_BASE+i]));
  end
endmodule

bind fxc_unit fxc_unit_chk #(
  .NUM_FIXED(NUM_FIXED), .CNT_W(CNT_W), .DATA_W(DATA_W),
  .GLB_W(GLB_W), .FIXED_BASE(FIXED_BASE), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_ctrl_i(glb_ctrl_i),
  .ovf_clr_valid_i(ovf_clr_valid_i), .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o), .glb_status_o(glb_status_o), .irq_o(irq_o)
);

// File: tb/fxc_unit_test.sv
`timescale 1ns/1ps
module fxc_unit_test;
  localparam int NF = 3, CW = 48, DW = 64, GW = 64, FB = 32, AW = 4;
  localparam logic [CW-1:0] ONES = {CW{1'b1}};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [NF-1:0] event_i;
  logic          user_mode_i;
  logic [GW-1:0] glb_ctrl_i;
  logic          ovf_clr_valid_i;
  logic [GW-1:0] ovf_clr_data_i;
  logic          wr_en_i;
  logic [AW-1:0] wr_addr_i;
  logic [DW-1:0] wr_data_i;
  logic [AW-1:0] rd_addr_i;
  logic [DW-1:0] rd_data_o;
  logic [GW-1:0] glb_status_o;
  logic          irq_o;

  fxc_unit #(.NUM_FIXED(NF), .CNT_W(CW), .DATA_W(DW), .GLB_W(GW),
             .FIXED_BASE(FB), .ADDR_W(AW)) uut (.*);

  logic [CW-1:0]   mcnt [NF];
  logic [4*NF-1:0] mctl;
  logic [NF-1:0]   mstat;
  logic            mirq;
  int checks = 0, errors = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [NF-1:0]   wrapv = '0;
    logic [NF-1:0]   pmiv  = '0;
    logic [NF-1:0]   clrv  = '0;
    logic [4*NF-1:0] nctl  = mctl;
    for (int i = 0; i < NF; i++) begin
      logic [3:0] f;
      logic       allow;
      f       = mctl[4*i +: 4];
      pmiv[i] = f[3];
      allow   = user_mode_i ? f[1] : f[0];
      if (wr_en_i && wr_addr_i == AW'(i + 1)) mcnt[i] = wr_data_i[CW-1:0];
      else if (event_i[i] && glb_ctrl_i[FB+i] && allow) begin
        if (mcnt[i] == ONES) wrapv[i] = 1'b1;
        mcnt[i] = mcnt[i] + 1'b1;
      end
    end
    if (wr_en_i && wr_addr_i == '0) begin
      nctl = wr_data_i[4*NF-1:0];
      for (int i = 0; i < NF; i++) nctl[4*i+2] = 1'b0;
    end
    mctl = nctl;
    if (ovf_clr_valid_i) clrv = ovf_clr_data_i[FB +: NF];
    mirq  = |(wrapv & pmiv);
    mstat = (mstat & ~clrv) | wrapv;
  endtask

  task automatic compare(string tag);
    logic [GW-1:0] es = '0;
    for (int a = 0; a <= NF + 1; a++) begin
      logic [DW-1:0] e = '0;
      rd_addr_i = AW'(a);
      #0.1;
      if (a == 0) e[4*NF-1:0] = mctl;
      else if (a <= NF) e[CW-1:0] = mcnt[a-1];
      chk(tag, rd_data_o, e);
    end
    es[FB +: NF] = mstat;
    chk(tag, glb_status_o, es);
    chk(tag, 64'(irq_o), 64'(mirq));
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    event_i = '0; wr_en_i = 1'b0; ovf_clr_valid_i = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    cyc(tag);
    wr_en_i = 1'b0;
  endtask

  initial begin
    #(4ns * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; idle(); user_mode_i = 1'b0; glb_ctrl_i = '0;
    ovf_clr_data_i = '0; wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0;
    for (int i = 0; i < NF; i++) mcnt[i] = '0;
    mctl = '0; mstat = '0; mirq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R10 reset state");

    wr('0, '1, "R2 reserved bit reads zero");
    glb_ctrl_i = '1;
    wr('0, 64'h1, "R1 kernel-only field");
    user_mode_i = 1'b1; event_i = 3'b001;
    cyc("R1 user mode blocked");
    user_mode_i = 1'b0;
    cyc("R1 kernel mode counts");
    idle(); wr('0, 64'h2, "R1 user-only field");
    user_mode_i = 1'b1; event_i = 3'b001;
    cyc("R1 user mode counts");
    glb_ctrl_i[FB] = 1'b0;
    cyc("R3 global bit gates counting");
    glb_ctrl_i = '1; idle();

    wr('0, 64'h0B0, "R9 setup");
    event_i = 3'b010;
    wr(AW'(2), 64'h5, "R9 write beats event");
    cyc("R3 counts after write");
    idle(); user_mode_i = 1'b0;

    wr('0, 64'h00B, "R8 setup");
    wr(AW'(1), 64'hABCD_0000_0000_0000 | 64'(ONES), "R5 write truncated");
    event_i = 3'b001;
    cyc("R6 wrap sets status and R8 irq");
    idle();
    cyc("R8 irq lasts one cycle");
    wr('0, 64'h003, "R8 setup no interrupt");
    wr(AW'(1), 64'(ONES), "R5 load all ones");
    event_i = 3'b001;
    cyc("R8 no irq without bit 3");
    idle();
    wr('0, 64'h00B, "R7 setup");
    wr(AW'(1), 64'(ONES), "R7 load all ones");
    event_i = 3'b001; ovf_clr_valid_i = 1'b1; ovf_clr_data_i = 64'(1) << FB;
    cyc("R7 wrap beats clear");
    idle(); ovf_clr_valid_i = 1'b1;
    cyc("R7 clear bit");
    idle();
    wr('0, 64'h0, "R4 stop all");
    event_i = '1;
    cyc("R4 stopped counter holds");
    cyc("R4 stopped counter holds again");
    idle();

    for (int n = 0; n < 4000; n++) begin
      event_i     = NF'($urandom);
      user_mode_i = 1'($urandom);
      glb_ctrl_i  = {$urandom, $urandom};
      if ($urandom_range(3) != 0) glb_ctrl_i[FB +: NF] = '1;
      ovf_clr_valid_i = ($urandom_range(5) == 0);
      ovf_clr_data_i  = {$urandom, $urandom};
      wr_en_i   = ($urandom_range(7) == 0);
      wr_addr_i = AW'($urandom_range(NF));
      wr_data_i = {$urandom, $urandom};
      if (wr_addr_i != '0 && $urandom_range(1) == 0)
        wr_data_i[CW-1:0] = ONES - CW'($urandom_range(3));
      cyc("R3 R5 R6 R7 R8 R9 random mix");
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule